// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects a clocked requester to an external 256K x 8 asynchronous static RAM. The requester presents one read or one write at a time on a valid/ready handshake, with an 18-bit word address and 8-bit write data. The controller turns each request into a timed pin sequence on the memory. It drives the address, an active-low and an active-high chip select, the active-low output enable and the active-low write enable. It also drives the data, and a drive enable for the pad buffer that sits outside this block. A read returns its byte with a one-cycle valid strobe.

The memory has no clock, so every access is held for `WAIT_CYC` clock cycles. Set this parameter so that `WAIT_CYC` times the clock period covers the access time of the speed grade fitted. The default of 9 cycles at 8 ns gives 72 ns. The memory is fully static and needs no refresh. Between accesses the controller deselects it so that it sits in standby.

Top module: `sram_port_ctrl`

## Requirements
- R1: Out of reset, and whenever `req_ready` is high, the memory is in standby: `mem_ce1_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0. `req_ready` is 1 after reset.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the access has finished. `req_ready` is never 1 while the memory is selected (`mem_ce1_n`=0 or `mem_ce2`=1).
- R3: `mem_addr` equals the taken request's address and does not change while the memory stays selected.
- R4: A read (`req_we`=0) selects the memory with `mem_we_n`=1 and holds `mem_oe_n`=0 for exactly `WAIT_CYC` consecutive cycles. `mem_dq_oe` stays 0 throughout.
- R5: Read data is sampled from `mem_dq_i` in the last cycle of the `mem_oe_n`=0 window. It appears on `rd_data` with `rd_valid`=1 for exactly one cycle, in the cycle after that window. Reads return the byte last written to that address, or 0 where no write has been made.
- R6: A write (`req_we`=1) holds `mem_we_n`=0 for exactly `WAIT_CYC` consecutive cycles. `mem_oe_n` stays 1 whenever `mem_we_n` is 0.
- R7: During a write, `mem_dq_oe` is 1 in the cycle before `mem_we_n` falls, during the whole pulse, and in the cycle after `mem_we_n` rises. `mem_dq_o` carries the request's write data, unchanged, across that span.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0, nor in the cycle right after a cycle with `mem_oe_n`=0.
- R9: After every access the memory is deselected before the next access begins. There is at least one cycle with `mem_ce1_n`=1 and `mem_ce2`=0 between two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle strobe for returned read data |
| rd_data | output | 8 | Returned read data |
| mem_addr | output | 18 | Memory address bus |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pad buffer |
| mem_dq_i | input | 8 | Data received from the memory pads |

## Verification
The assertions assume that `req_addr`, `req_we` and `req_wdata` hold steady while `req_valid` waits for `req_ready`. They also assume that the memory puts valid data on `mem_dq_i` by the last cycle of a read window. The bench's memory model honours the second assumption exactly. It returns a poison byte until the read window reaches its last cycle, so a read sampled early shows up as a data mismatch. The driver changes request fields only on falling edges, and it holds them until the cycle after the request is taken.

// File: rtl/sram_ctrl_pkg.sv
// Shared types for the static RAM access controller.
// Assumes: one access in flight at a time; pin levels are a pure function of
// the sequencer state, so the decode lives here and is registered by the user.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_TURN  = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5
    } acc_state_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } pin_ctl_s;

    localparam pin_ctl_s PINS_STANDBY = '{ce1_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    // Map a sequencer state to the control pin levels it needs.
    function automatic pin_ctl_s decode_pins(input acc_state_e st);
        pin_ctl_s p;
        p = PINS_STANDBY;
        case (st)
            ST_RD_ACC: begin
                p.ce1_n = 1'b0;
                p.ce2   = 1'b1;
                p.oe_n  = 1'b0;
            end
            ST_WR_SETUP, ST_WR_HOLD: begin
                p.ce1_n = 1'b0;
                p.ce2   = 1'b1;
                p.dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                p.ce1_n = 1'b0;
                p.ce2   = 1'b1;
                p.we_n  = 1'b0;
                p.dq_oe = 1'b1;
            end
            default: p = PINS_STANDBY;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_access_fsm.sv
// Access sequencer: takes one request at a time and steps through the read or
// write phases, counting WAIT_CYC cycles for the timed phase.
// Assumes: WAIT_CYC >= 1; request fields are held while req_valid waits.
module sram_access_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int WAIT_CYC = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_we,
    output logic       req_ready,
    output logic       accept,
    output acc_state_e state_q,
    output acc_state_e state_d,
    output logic       last_cyc
);

    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             timed_phase;

    assign req_ready   = (state_q == ST_IDLE);
    assign accept      = req_valid && req_ready;
    assign timed_phase = (state_q == ST_RD_ACC) || (state_q == ST_WR_PULSE);
    assign last_cyc    = timed_phase && (cnt_q == CNT_LAST);

    // Next-state selection for the access sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (accept) state_d = req_we ? ST_WR_SETUP : ST_RD_ACC;
            ST_RD_ACC:   if (last_cyc) state_d = ST_RD_TURN;
            ST_RD_TURN:  state_d = ST_IDLE;
            ST_WR_SETUP: state_d = ST_WR_PULSE;
            ST_WR_PULSE: if (last_cyc) state_d = ST_WR_HOLD;
            ST_WR_HOLD:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Wait counter: runs only in the timed phases, restarts at zero on entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (timed_phase && !last_cyc) cnt_q <= cnt_q + 1'b1;
        else                            cnt_q <= '0;
    end

    // R2: a taken request makes the controller busy on the next cycle.
    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

endmodule

// File: rtl/sram_pin_driver.sv
// Memory pin registers: every control pin, the address and the write data come
// straight from a flop, so the memory never sees decode glitches.
// Assumes: state_d is the sequencer's next state; accept marks a taken request.
module sram_pin_driver
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_state_e        state_d,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe
);

    pin_ctl_s             ctl_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    wdata_q;

    // Control pins follow the decoded next state, one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= PINS_STANDBY;
        else        ctl_q <= decode_pins(state_d);
    end

    // Address and write data are captured once per request and then held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    assign mem_addr  = addr_q;
    assign mem_dq_o  = wdata_q;
    assign mem_ce1_n = ctl_q.ce1_n;
    assign mem_ce2   = ctl_q.ce2;
    assign mem_oe_n  = ctl_q.oe_n;
    assign mem_we_n  = ctl_q.we_n;
    assign mem_dq_oe = ctl_q.dq_oe;

    // R6: output enable stays off while the write strobe is low.
    assert_oe_off_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R8: no drive in the cycle after the memory was allowed to drive.
    assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mem_oe_n) |-> !mem_dq_oe);

    // R8: the two drivers are never enabled together.
    assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

endmodule

// File: rtl/sram_read_capture.sv
// Read return path: samples the memory data in the last cycle of the read
// window and presents it with a one-cycle strobe.
// Assumes: mem_dq_i is settled by the last wait cycle (WAIT_CYC sized for it).
module sram_read_capture
    import sram_ctrl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_state_e        state_q,
    input  logic              last_cyc,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic take;

    assign take = (state_q == ST_RD_ACC) && last_cyc;

    // Capture register and strobe for returned read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= take;
            if (take) rd_data <= mem_dq_i;
        end
    end

    // R5: the strobe lasts exactly one cycle.
    assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_port_ctrl.sv
// Top of the static RAM access controller: sequencer, pin registers and read
// return path. The data pad buffer is outside; mem_dq_oe enables its driver.
// Assumes: WAIT_CYC * clock period covers the memory's access time.
module sram_port_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 8,
    parameter int WAIT_CYC = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    acc_state_e state_q;
    acc_state_e state_d;
    logic       accept;
    logic       last_cyc;

    sram_access_fsm #(.WAIT_CYC(WAIT_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_ready (req_ready),
        .accept    (accept),
        .state_q   (state_q),
        .state_d   (state_d),
        .last_cyc  (last_cyc)
    );

    sram_pin_driver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d   (state_d),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_addr  (mem_addr),
        .mem_ce1_n (mem_ce1_n),
        .mem_ce2   (mem_ce2),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe)
    );

    sram_read_capture #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_q  (state_q),
        .last_cyc (last_cyc),
        .mem_dq_i (mem_dq_i),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // R1: while ready, the memory is deselected and nothing drives the bus.
    assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe));

    // R2: never ready while the memory is selected.
    assert_busy_while_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce1_n || mem_ce2) |-> !req_ready);

    // R3: address holds while the memory stays selected.
    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

    // R7: data is driven in the cycle before the write strobe falls.
    assert_setup_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(mem_dq_oe) && mem_dq_oe));

    // R7: data is still driven in the cycle after the write strobe rises.
    assert_hold_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o)));

    // R9: an access ends with the memory deselected for a cycle.
    assert_deselect_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_ce1_n) && !mem_ce1_n) |-> $past(!mem_ce2));

endmodule

// File: tb/sim_sram_port_ctrl.sv
// Scoreboard bench: the driver task pushes expected read bytes into a queue,
// the monitor pops them on rd_valid; a pin monitor checks the timing rules.
module sim_sram_port_ctrl;

    localparam int W  = 9;
    localparam int AW = 18;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [DW-1:0] exp_mem [bit [AW-1:0]];
    logic [DW-1:0] ram     [bit [AW-1:0]];
    logic [DW-1:0] rd_q [$];

    always #4 clk = ~clk;

    sram_port_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYC(W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- memory model ----------------
    logic sel, rd_drive;
    int   rd_age = 0;
    logic          wr_pend = 1'b0;
    logic [AW-1:0] wr_a;
    logic [DW-1:0] wr_d;

    assign sel      = !mem_ce1_n && mem_ce2;
    assign rd_drive = sel && mem_we_n && !mem_oe_n;
    assign mem_dq_i = (rd_drive && rd_age >= W - 1)
                      ? (ram.exists(mem_addr) ? ram[mem_addr] : 8'h00) : 8'hEE;

    always @(posedge clk) begin
        rd_age <= rd_drive ? rd_age + 1 : 0;
        if (sel && !mem_we_n) begin
            wr_pend <= 1'b1;
            wr_a    <= mem_addr;
            wr_d    <= mem_dq_oe ? mem_dq_o : 8'hXX;
        end else if (wr_pend) begin
            wr_pend <= 1'b0;
            ram[wr_a] = wr_d;
        end
    end

    // ---------------- pin monitor ----------------
    int we_run = 0, oe_run = 0;
    logic p_we_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0, p_sel = 1'b0, p_rdv = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_dq_o = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) we_run++;
            else if (we_run > 0) begin check(we_run == W, "R6 write pulse width", we_run, W); we_run = 0; end
            if (!mem_oe_n) oe_run++;
            else if (oe_run > 0) begin check(oe_run == W, "R4 read window width", oe_run, W); oe_run = 0; end
            if (!mem_we_n && !mem_oe_n) check(0, "R6 oe during write", 0, 1);
            if (!mem_oe_n && (mem_dq_oe || !mem_we_n)) check(0, "R4 read drive/we", 1, 0);
            if (p_we_n && !mem_we_n) check(p_dq_oe, "R7 setup drive", p_dq_oe, 1);
            if (!p_we_n && mem_we_n) check(mem_dq_oe && mem_dq_o == p_dq_o, "R7 hold drive", mem_dq_o, p_dq_o);
            if (!mem_we_n && p_dq_oe && mem_dq_o != p_dq_o) check(0, "R7 data steady", mem_dq_o, p_dq_o);
            if (mem_dq_oe && (!mem_oe_n || !p_oe_n)) check(0, "R8 turnaround", 1, 0);
            if (sel && p_sel && mem_addr != p_addr) check(0, "R3 addr stable", mem_addr, p_addr);
            if (req_ready)
                check(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 standby when ready",
                      {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
            if (p_rdv && rd_valid) check(0, "R5 strobe width", 2, 1);
            if (rd_valid) begin
                if (rd_q.size() == 0) check(0, "R5 unexpected read data", rd_data, 0);
                else begin
                    logic [DW-1:0] e;
                    e = rd_q.pop_front();
                    check(rd_data == e, "R5 read data", rd_data, e);
                end
            end
        end
        p_we_n = mem_we_n; p_oe_n = mem_oe_n; p_dq_oe = mem_dq_oe;
        p_sel = sel; p_addr = mem_addr; p_dq_o = mem_dq_o; p_rdv = rd_valid;
    end

    // R9: count selected periods and check a deselect cycle separates accesses.
    int sel_starts = 0;
    always @(negedge clk) if (rst_n && sel && !p_sel) sel_starts++;

    // ---------------- driver ----------------
    int issued = 0;

    task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (we) exp_mem[a] = d;
        else    rd_q.push_back(exp_mem.exists(a) ? exp_mem[a] : 8'h00);
        issued++;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R2 busy after accept", req_ready, 0);
        if (sel) check(mem_addr == a, "R3 address matches request", mem_addr, a);
    endtask

    task automatic drain();
        int n = 0;
        while ((!req_ready || rd_q.size() != 0) && n < 1000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid,
              "R1 reset pins", {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R1 ready after reset", req_ready, 1);

        issue(1'b1, 18'h00000, 8'hA5);
        issue(1'b1, 18'h3FFFF, 8'h5A);
        issue(1'b0, 18'h00000, 8'h00);
        issue(1'b0, 18'h3FFFF, 8'h00);
        issue(1'b0, 18'h12345, 8'h00);
        // read then write then read of one address, back to back (R8, R9)
        issue(1'b0, 18'h00100, 8'h00);
        issue(1'b1, 18'h00100, 8'hC3);
        issue(1'b0, 18'h00100, 8'h00);
        issue(1'b1, 18'h00100, 8'hFF);
        issue(1'b1, 18'h00100, 8'h00);
        issue(1'b0, 18'h00100, 8'h00);
        for (int i = 0; i < 40; i++) begin
            logic [AW-1:0] a;
            a = AW'((i * 7919) & 18'h0003F);
            issue(i % 3 != 0, a, DW'(i * 37 + 3));
            if (i % 5 == 0) repeat (i % 4 + 1) @(negedge clk);
        end
        drain();
        check(rd_q.size() == 0, "R5 all reads returned", rd_q.size(), 0);
        check(sel_starts == issued, "R9 one select period per access", sel_starts, issued);
        repeat (5) @(negedge clk);
        check(mem_ce1_n && !mem_ce2 && !mem_dq_oe && req_ready, "R1 standby after drain",
              {mem_ce1_n, mem_ce2, mem_dq_oe, req_ready}, 4'b1001);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule